// File: doc/BRIEF.md
# Limited-Pointer Sharer List

This block holds the sharer state of one directory entry in a cache-coherent system. It does not keep one presence bit per node. It stores a few node ids, each as a binary pointer of log2(NODES) bits. When a read miss adds a node, the block records it. When a write comes in, the block is asked for the set of nodes that must be invalidated. It answers with a NODES-bit mask one cycle later.

A new sharer can arrive when every pointer slot is already used. The `policySel` input picks what happens then:
- **Broadcast (0).** The entry falls back to broadcast.
- **Displacement (1).** The new sharer displaces the oldest stored one, and the displaced id is reported for invalidation.
- **Coarse vector (2).** The entry is reinterpreted as a coarse vector with one bit per group of GROUP consecutive nodes.

Code 3 acts as broadcast. The policy is meant to change only together with a clear. A clear returns the entry to its empty pointer form.

Top module: `lpSharerList`

## Requirements
- R1: After reset the entry is empty in pointer form: a query returns an all-zero mask and `victimValid` is low.
- R2: In pointer form, a query raised in one cycle gives `invValid` high in the next cycle, and `invMask` has bit n set exactly for each stored sharer n.
- R3: Adding a node that is already stored changes nothing: the mask is unchanged, no overflow action occurs, and no victim is reported.
- R4: Under policy code 0, adding a new node when all PTRS slots are used puts the entry in broadcast form. Queries then return every node. Further adds change nothing until a clear.
- R5: Under policy code 1, adding a new node to a full entry replaces the oldest stored sharer. In the cycle after the add, `victimValid` pulses high with `victimNode` equal to the replaced id. The entry stays in pointer form.
- R6: Under policy code 2, adding a new node to a full entry switches to coarse form. Group g (nodes g*GROUP to g*GROUP+GROUP-1) is marked if any stored sharer or the new node lies in it. Later adds mark their group, and a query sets every node of each marked group.
- R7: The mask never contains the node given as `queryNode`, in any form.
- R8: `clearAll` returns the entry to empty pointer form. It takes priority over an add in the same cycle, and that add is dropped.
- R9: A query made in the same cycle as an add reports the state before that add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| policySel | input | 2 | Overflow policy: 0 broadcast, 1 displace oldest, 2 coarse vector, 3 broadcast |
| addValid | input | 1 | Record `addNode` as a sharer |
| addNode | input | log2(NODES) | Id of the node to add |
| clearAll | input | 1 | Drop all sharers, return to pointer form |
| queryValid | input | 1 | Request invalidation targets for a write |
| queryNode | input | log2(NODES) | Id of the writing node |
| invValid | output | 1 | Mask valid, one cycle after `queryValid` |
| invMask | output | NODES | Nodes to invalidate |
| victimValid | output | 1 | A sharer was displaced by the previous add |
| victimNode | output | log2(NODES) | Id of the displaced sharer |

## Verification
The bench builds the block with 16 nodes, 3 pointer slots and groups of 4. With these values:
- A fourth distinct sharer already overflows the entry.
- A pair of displacements rotates the replacement slot through most of its range.
- Four coarse groups let a single coarse mask show both marked and unmarked groups.

Random add, clear and query mixes run under each policy in turn. Directed cases cover these corners:
- duplicate adds on a full entry;
- a clear coinciding with an add;
- a query coinciding with an add;
- a writer that is itself a sharer.

// File: rtl/lpShrPkg.sv
package lpShrPkg;

  typedef enum logic [1:0] {
    MODE_PTR    = 2'd0,
    MODE_BCAST  = 2'd1,
    MODE_COARSE = 2'd2
  } modeT;

  typedef enum logic [1:0] {
    POL_BCAST  = 2'd0,
    POL_EVICT  = 2'd1,
    POL_COARSE = 2'd2,
    POL_SPARE  = 2'd3
  } policyT;

  // strobes from the control to the datapath, at most one active per cycle
  typedef struct packed {
    logic clear;      // drop every pointer and coarse bit
    logic fill;       // write new id into the first free slot
    logic evict;      // overwrite the round-robin slot, report its old id
    logic fold;       // build coarse vector from pointers plus new id
    logic markGroup;  // set the group bit of the new id
  } stepT;

endpackage

// File: rtl/lpShrCtrl.sv
module lpShrCtrl
  import lpShrPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       addValid,
  input  logic       clearAll,
  input  logic [1:0] policySel,
  input  logic       hit,
  input  logic       full,
  output stepT       step,
  output modeT       mode
);

  modeT   modeNext;
  policyT policy;

  assign policy = policyT'(policySel);

  always_comb begin
    step     = '0;
    modeNext = mode;
    if (clearAll) begin
      step.clear = 1'b1;
      modeNext   = MODE_PTR;
    end else if (addValid) begin
      unique case (mode)
        MODE_PTR: begin
          if (hit) begin
            step = '0;
          end else if (!full) begin
            step.fill = 1'b1;
          end else begin
            unique case (policy)
              POL_EVICT: step.evict = 1'b1;
              POL_COARSE: begin
                step.fold = 1'b1;
                modeNext  = MODE_COARSE;
              end
              default: modeNext = MODE_BCAST;
            endcase
          end
        end
        MODE_COARSE: step.markGroup = 1'b1;
        default:     step = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) mode <= MODE_PTR;
    else       mode <= modeNext;
  end

  // only one datapath action per cycle
  assert_one_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({step.clear, step.fill, step.evict, step.fold, step.markGroup}));

  // clear always lands in pointer form
  assert_clear_to_ptr_R8: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> (mode == MODE_PTR));

  // broadcast form is held until a clear
  assert_bcast_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_BCAST && !clearAll) |=> (mode == MODE_BCAST));

  // displacement policy never leaves pointer form
  assert_evict_stays_ptr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_PTR && policy == POL_EVICT) |=> (mode == MODE_PTR));

endmodule

// File: rtl/lpShrData.sv
module lpShrData
  import lpShrPkg::*;
#(
  parameter int NODES = 16,
  parameter int PTRS  = 3,
  parameter int GROUP = 4,
  localparam int IDW    = $clog2(NODES),
  localparam int GROUPS = NODES / GROUP,
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int GSH    = $clog2(GROUP),
  localparam int SLW    = (PTRS > 1) ? $clog2(PTRS) : 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  stepT             step,
  input  modeT             mode,
  input  logic             addValid,
  input  logic [IDW-1:0]   addNode,
  input  logic             queryValid,
  input  logic [IDW-1:0]   queryNode,
  output logic             hit,
  output logic             full,
  output logic             invValid,
  output logic [NODES-1:0] invMask,
  output logic             victimValid,
  output logic [IDW-1:0]   victimNode
);

  logic [PTRS-1:0][IDW-1:0] ptrId;
  logic [PTRS-1:0]          ptrVld;
  logic [SLW-1:0]           rrIdx;
  logic [SLW-1:0]           freeIdx;
  logic [GROUPS-1:0]        coarseVec;
  logic [GROUPS-1:0]        foldVec;
  logic [PTRS-1:0]          slotHit;
  logic [NODES-1:0]         ptrMask;
  logic [NODES-1:0]         coarseMask;
  logic [NODES-1:0]         rawMask;
  logic [NODES-1:0]         selfHot;

  function automatic logic [GW-1:0] groupOf(input logic [IDW-1:0] id);
    logic [IDW-1:0] sh;
    sh = id >> GSH;
    return sh[GW-1:0];
  endfunction

  // per-slot compare
  for (genvar i = 0; i < PTRS; i++) begin : gSlot
    assign slotHit[i] = ptrVld[i] && (ptrId[i] == addNode);
  end

  assign hit  = |slotHit;
  assign full = &ptrVld;

  always_comb begin
    freeIdx = '0;
    for (int i = PTRS - 1; i >= 0; i--) begin
      if (!ptrVld[i]) freeIdx = SLW'(i);
    end
  end

  // pointers folded into group bits, new id included
  always_comb begin
    foldVec = '0;
    for (int i = 0; i < PTRS; i++) begin
      if (ptrVld[i]) foldVec[groupOf(ptrId[i])] = 1'b1;
    end
    foldVec[groupOf(addNode)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrId       <= '0;
      ptrVld      <= '0;
      rrIdx       <= '0;
      coarseVec   <= '0;
      victimValid <= 1'b0;
      victimNode  <= '0;
    end else begin
      victimValid <= 1'b0;
      if (step.clear) begin
        ptrVld    <= '0;
        rrIdx     <= '0;
        coarseVec <= '0;
      end
      if (step.fill) begin
        ptrId[freeIdx]  <= addNode;
        ptrVld[freeIdx] <= 1'b1;
      end
      if (step.evict) begin
        victimValid   <= 1'b1;
        victimNode    <= ptrId[rrIdx];
        ptrId[rrIdx]  <= addNode;
        rrIdx         <= (rrIdx == SLW'(PTRS - 1)) ? '0 : rrIdx + 1'b1;
      end
      if (step.fold) begin
        coarseVec <= foldVec;
      end
      if (step.markGroup) begin
        coarseVec[groupOf(addNode)] <= 1'b1;
      end
    end
  end

  // mask sources
  always_comb begin
    ptrMask = '0;
    for (int i = 0; i < PTRS; i++) begin
      if (ptrVld[i]) ptrMask[ptrId[i]] = 1'b1;
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : gGroup
    assign coarseMask[g*GROUP +: GROUP] = {GROUP{coarseVec[g]}};
  end

  always_comb begin
    unique case (mode)
      MODE_BCAST:  rawMask = '1;
      MODE_COARSE: rawMask = coarseMask;
      default:     rawMask = ptrMask;
    endcase
  end

  assign selfHot = NODES'(1) << queryNode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      invValid <= 1'b0;
      invMask  <= '0;
    end else begin
      invValid <= queryValid;
      invMask  <= queryValid ? (rawMask & ~selfHot) : '0;
    end
  end

  // writer never appears among its own targets
  assert_no_self_R7: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> !invMask[$past(queryNode)]);

  // duplicate add in pointer form leaves the slots untouched
  assert_dup_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (addValid && hit && mode == MODE_PTR && !step.clear) |=>
      ($stable(ptrVld) && $stable(ptrId)));

  // a victim is only reported after an add into a full entry
  assert_victim_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> ($past(full) && $past(addValid) && !$past(hit)));

  // pointer slots only vanish through a clear
  assert_slots_keep_R2: assert property (@(posedge clk) disable iff (!rstN)
    !step.clear |=> ($countones(ptrVld) >= $countones($past(ptrVld))));

endmodule

// File: rtl/lpSharerList.sv
module lpSharerList
  import lpShrPkg::*;
#(
  parameter int NODES = 16,
  parameter int PTRS  = 3,
  parameter int GROUP = 4,
  localparam int IDW  = $clog2(NODES)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       policySel,
  input  logic             addValid,
  input  logic [IDW-1:0]   addNode,
  input  logic             clearAll,
  input  logic             queryValid,
  input  logic [IDW-1:0]   queryNode,
  output logic             invValid,
  output logic [NODES-1:0] invMask,
  output logic             victimValid,
  output logic [IDW-1:0]   victimNode
);

  stepT step;
  modeT mode;
  logic hit;
  logic full;

  lpShrCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .addValid  (addValid),
    .clearAll  (clearAll),
    .policySel (policySel),
    .hit       (hit),
    .full      (full),
    .step      (step),
    .mode      (mode)
  );

  lpShrData #(
    .NODES (NODES),
    .PTRS  (PTRS),
    .GROUP (GROUP)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .step        (step),
    .mode        (mode),
    .addValid    (addValid),
    .addNode     (addNode),
    .queryValid  (queryValid),
    .queryNode   (queryNode),
    .hit         (hit),
    .full        (full),
    .invValid    (invValid),
    .invMask     (invMask),
    .victimValid (victimValid),
    .victimNode  (victimNode)
  );

endmodule

// File: tb/lpSharerList_test.sv
module lpSharerList_test;

  localparam int NODES  = 16;
  localparam int PTRS   = 3;
  localparam int GROUP  = 4;
  localparam int IDW    = 4;
  localparam int GROUPS = NODES / GROUP;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       policySel = 2'd0;
  logic             addValid = 1'b0;
  logic [IDW-1:0]   addNode = '0;
  logic             clearAll = 1'b0;
  logic             queryValid = 1'b0;
  logic [IDW-1:0]   queryNode = '0;
  logic             invValid;
  logic [NODES-1:0] invMask;
  logic             victimValid;
  logic [IDW-1:0]   victimNode;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model: 0 pointer, 1 broadcast, 2 coarse
  int mMode;
  int mCnt;
  int mIds[PTRS];
  bit mCv[GROUPS];
  int mPol;
  bit expVict;
  int expVictId;

  always #2 clk = ~clk;

  lpSharerList #(.NODES(NODES), .PTRS(PTRS), .GROUP(GROUP)) uut (
    .clk(clk), .rstN(rstN), .policySel(policySel), .addValid(addValid),
    .addNode(addNode), .clearAll(clearAll), .queryValid(queryValid),
    .queryNode(queryNode), .invValid(invValid), .invMask(invMask),
    .victimValid(victimValid), .victimNode(victimNode)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NODES-1:0] expMask(input int w);
    logic [NODES-1:0] m = '0;
    if (mMode == 1) m = '1;
    else if (mMode == 2) begin
      for (int g = 0; g < GROUPS; g++)
        if (mCv[g]) m[g*GROUP +: GROUP] = '1;
    end else begin
      for (int i = 0; i < mCnt; i++) m[mIds[i]] = 1'b1;
    end
    m[w] = 1'b0;
    return m;
  endfunction

  function automatic void modelClear();
    mMode = 0; mCnt = 0;
    for (int g = 0; g < GROUPS; g++) mCv[g] = 0;
  endfunction

  function automatic void modelAdd(input int n);
    bit present = 0;
    expVict = 0;
    if (mMode == 2) begin
      mCv[n / GROUP] = 1;
      return;
    end
    if (mMode == 1) return;
    for (int i = 0; i < mCnt; i++) if (mIds[i] == n) present = 1;
    if (present) return;
    if (mCnt < PTRS) begin
      mIds[mCnt] = n; mCnt++;
    end else if (mPol == 1) begin
      expVict = 1; expVictId = mIds[0];
      for (int i = 0; i < PTRS - 1; i++) mIds[i] = mIds[i+1];
      mIds[PTRS-1] = n;
    end else if (mPol == 2) begin
      for (int i = 0; i < mCnt; i++) mCv[mIds[i] / GROUP] = 1;
      mCv[n / GROUP] = 1;
      mMode = 2;
    end else begin
      mMode = 1;
    end
  endfunction

  task automatic doAdd(input int n, input string req);
    addValid = 1'b1; addNode = IDW'(n);
    modelAdd(n);
    @(posedge clk); @(negedge clk);
    addValid = 1'b0;
    check(victimValid == expVict, req, {31'd0, victimValid}, {31'd0, expVict});
    if (expVict)
      check(victimNode == IDW'(expVictId), req, {28'd0, victimNode}, expVictId);
  endtask

  task automatic doClear();
    clearAll = 1'b1;
    modelClear();
    @(posedge clk); @(negedge clk);
    clearAll = 1'b0;
  endtask

  task automatic doQuery(input int w, input string req);
    logic [NODES-1:0] e;
    e = expMask(w);
    queryValid = 1'b1; queryNode = IDW'(w);
    @(posedge clk); @(negedge clk);
    queryValid = 1'b0;
    check(invValid == 1'b1, req, {31'd0, invValid}, 32'd1);
    check(invMask == e, req, {16'd0, invMask}, {16'd0, e});
  endtask

  task automatic setPolicy(input int p);
    policySel = 2'(p); mPol = p;
    doClear();
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    modelClear(); mPol = 0; expVict = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(victimValid == 1'b0, "R1", {31'd0, victimValid}, 32'd0);
    check(invValid == 1'b0, "R1", {31'd0, invValid}, 32'd0);
    doQuery(0, "R1");

    // R2, R7, R3 under broadcast policy
    setPolicy(0);
    doAdd(3, "R2"); doAdd(9, "R2");
    doQuery(0, "R2");
    doQuery(3, "R7");
    doAdd(9, "R3"); doAdd(12, "R2"); doAdd(3, "R3");
    doQuery(0, "R3");
    // R4 overflow to broadcast
    doAdd(5, "R4");
    doQuery(0, "R4");
    doAdd(7, "R4");
    doQuery(6, "R4");

    // R8 clear beats same-cycle add
    clearAll = 1'b1; addValid = 1'b1; addNode = 4'd1;
    modelClear();
    @(posedge clk); @(negedge clk);
    clearAll = 1'b0; addValid = 1'b0;
    doQuery(0, "R8");

    // R9 query sees state before same-cycle add
    addValid = 1'b1; addNode = 4'd4; queryValid = 1'b1; queryNode = 4'd0;
    @(posedge clk); @(negedge clk);
    addValid = 1'b0; queryValid = 1'b0;
    check(invValid == 1'b1 && invMask == '0, "R9", {16'd0, invMask}, 32'd0);
    modelAdd(4);
    doQuery(0, "R9");

    // R5 displacement of oldest
    setPolicy(1);
    doAdd(1, "R5"); doAdd(2, "R5"); doAdd(3, "R5");
    doAdd(2, "R3");
    doAdd(4, "R5"); doAdd(5, "R5");
    doQuery(0, "R5");
    doAdd(6, "R5");
    doQuery(3, "R5");

    // R6 coarse vector
    setPolicy(2);
    doAdd(1, "R6"); doAdd(2, "R6"); doAdd(6, "R6"); doAdd(9, "R6");
    doQuery(15, "R6");
    doAdd(0, "R6");
    doQuery(15, "R6");
    doAdd(13, "R6");
    doQuery(5, "R7");

    // random mixes under each policy
    for (int p = 0; p < 3; p++) begin
      setPolicy(p);
      for (int k = 0; k < 150; k++) begin
        int r;
        r = $urandom_range(99);
        if (r < 55) doAdd($urandom_range(NODES - 1), "R2");
        else if (r < 62) doClear();
        else doQuery($urandom_range(NODES - 1), "R7");
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule